// File: doc/BRIEF.md
# Peripheral Interrupt Aggregation Handler

This block gathers sixteen peripheral interrupt sources, such as capture and compare channels, and condenses them into two request lines toward a central interrupt controller. One line asks for a standard interrupt. The other asks for service by a hardware transaction server. A one-cycle event pulse on a source input latches that source's pending bit. A per-source enable bit decides whether the pending source may raise a request. A per-source steering bit decides which of the two lines it raises.

On each line the enabled pending source with the lowest index wins. When the acknowledge for a line arrives while that line is requesting, the handler clears the winner's pending bit in the same clock edge. One cycle later it presents the winner's service vector address, computed as a base parameter plus twice the source index. Software reaches the enable, pending and steering registers through a simple register port. It can clear pending bits through that port but cannot set them.

Top module: `pih_hub`

## Requirements
- R1: After reset the enable, pending and steering registers read zero, `std_req`, `srv_req` and `vec_valid` are low, and `vec_addr` is zero.
- R2: A 1 on `src_evt[i]` at a clock edge makes pending bit i read 1 after that edge, whatever the enable and steering bits hold.
- R3: A pending bit whose enable bit is 0 stays set and raises neither request line.
- R4: `std_req` is high exactly when some source is pending, enabled and has steering bit 0. `srv_req` is high exactly when some source is pending, enabled and has steering bit 1.
- R5: On each line the lowest-indexed qualifying source wins, and its vector address is `VEC_BASE + 2*index`.
- R6: `ack_std` (or `ack_srv`) sampled high while its line requests clears the winner's pending bit at that edge. `vec_valid` is then high for the next cycle, with `vec_addr` set to that winner's vector. An acknowledge while the line is idle clears nothing and leaves `vec_valid` low.
- R7: If both acknowledges are accepted at the same edge, both winners are cleared and `vec_addr` carries the server-line winner's vector.
- R8: A source event at the same edge as a clear of that bit, whether from an acknowledge or from a software write, leaves the pending bit set.
- R9: The register map is: address 0 holds the enable bits, address 1 the pending bits, address 2 the steering bits, and address 3 reads zero. Bit i of each register belongs to source i. A write to address 1 ANDs the data into the pending bits, so a 0 clears a bit and a 1 leaves it unchanged. Writes to addresses 0 and 2 load the data. `rd_data` follows `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data |
| src_evt | input | 16 | Per-source event pulses |
| ack_std | input | 1 | Acknowledge of the standard line |
| ack_srv | input | 1 | Acknowledge of the server line |
| std_req | output | 1 | Standard interrupt request |
| srv_req | output | 1 | Transaction-server request |
| vec_valid | output | 1 | Vector address valid, one cycle after an accepted acknowledge |
| vec_addr | output | 16 | Service vector address of the acknowledged source |

## Verification
The hardest cases to reach are the edges where a clear and a fresh event on the same bit coincide. The first is an acknowledge whose winner fires again in that very cycle. The second is a software clear racing an event. The third is an acceptance of both acknowledges at once, with one winner on each line. Directed sequences first arrange a known winner on each line and then fire these collisions deliberately. A long run of random events, acknowledges and register writes follows, compared against a bench model of the pending, enable and steering state. That run also reaches the collisions by chance, with different indices each time.

// File: rtl/pih_pkg.sv
// Package: shared register address encoding for the interrupt aggregation handler.
// Assumes a two-bit register address space.
package pih_pkg;
    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_PEND   = 2'd1,
        REG_STEER  = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/pih_regs.sv
// Module: per-source enable, pending and steering state.
// Pending bits are set by events, cleared by acknowledge clears or by
// software AND-writes; an event in the same cycle as a clear wins.
// Assumes clr_vec carries at most one bit per accepted acknowledge.
module pih_regs
    import pih_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [N-1:0] wr_data,
    input  logic [N-1:0] src_evt,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] enable_q,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] steer_q
);
    logic [N-1:0] pend_n;

    // Next pending value: software clear, then acknowledge clear, then events.
    always_comb begin
        pend_n = pend_q;
        if (wr_en && (wr_addr == REG_PEND))
            pend_n = pend_n & wr_data;
        pend_n = (pend_n & ~clr_vec) | src_evt;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            pend_q   <= '0;
            steer_q  <= '0;
        end else begin
            pend_q <= pend_n;
            if (wr_en && (wr_addr == REG_ENABLE))
                enable_q <= wr_data;
            if (wr_en && (wr_addr == REG_STEER))
                steer_q <= wr_data;
        end
    end
endmodule

// File: rtl/pih_pick.sv
// Module: fixed-priority picker; the lowest set bit of cand wins.
// Assumes IW is wide enough to index N candidates.
module pih_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  cand,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan from the top so that the lowest set index is the last assignment.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pih_vec.sv
// Module: registers the service vector of an accepted acknowledge.
// The server line takes the vector when both lines are accepted together.
// Assumes the accept inputs already include the line's request.
module pih_vec #(
    parameter int            IW       = 4,
    parameter int            VEC_W    = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_std,
    input  logic             take_srv,
    input  logic [IW-1:0]    idx_std,
    input  logic [IW-1:0]    idx_srv,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_addr
);
    logic [IW-1:0] idx_sel;

    // Choose which winner's index forms the vector.
    assign idx_sel = take_srv ? idx_srv : idx_std;

    // Vector register: loads base plus twice the index on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_addr  <= '0;
        end else begin
            vec_valid <= take_std || take_srv;
            if (take_std || take_srv)
                vec_addr <= VEC_BASE + (VEC_W'(idx_sel) << 1);
        end
    end
endmodule

// File: rtl/pih_hub.sv
// Module: top of the peripheral interrupt aggregation handler.
// Steers each enabled pending source to the standard or server request
// line, picks the lowest index per line, clears it on acknowledge and
// presents its vector. Assumes acknowledges are single-cycle pulses.
module pih_hub
    import pih_pkg::*;
#(
    parameter int               NUM_SRC  = 16,
    parameter int               VEC_W    = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h2000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic [1:0]         rd_addr,
    output logic [NUM_SRC-1:0] rd_data,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               ack_std,
    input  logic               ack_srv,
    output logic               std_req,
    output logic               srv_req,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_addr
);
    localparam int IW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int LINES = 2;   // line 0 standard, line 1 server

    logic [NUM_SRC-1:0] enable_q, pend_q, steer_q;
    logic [NUM_SRC-1:0] cand  [LINES];
    logic [NUM_SRC-1:0] clr   [LINES];
    logic [LINES-1:0]   hit, ack, take;
    logic [IW-1:0]      idx   [LINES];
    logic [NUM_SRC-1:0] clr_vec;

    assign ack = {ack_srv, ack_std};

    pih_regs #(.N(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .src_evt  (src_evt),
        .clr_vec  (clr_vec),
        .enable_q (enable_q),
        .pend_q   (pend_q),
        .steer_q  (steer_q)
    );

    // One candidate set, picker and clear vector per request line.
    for (genvar p = 0; p < LINES; p++) begin : g_line
        assign cand[p] = pend_q & enable_q & ((p == 1) ? steer_q : ~steer_q);

        pih_pick #(.N(NUM_SRC), .IW(IW)) u_pick (
            .cand (cand[p]),
            .hit  (hit[p]),
            .idx  (idx[p])
        );

        assign take[p] = ack[p] && hit[p];
        assign clr[p]  = take[p] ? (NUM_SRC'(1) << idx[p]) : '0;
    end

    assign clr_vec = clr[0] | clr[1];
    assign std_req = hit[0];
    assign srv_req = hit[1];

    pih_vec #(.IW(IW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_std  (take[0]),
        .take_srv  (take[1]),
        .idx_std   (idx[0]),
        .idx_srv   (idx[1]),
        .vec_valid (vec_valid),
        .vec_addr  (vec_addr)
    );

    // Combinational register read mux.
    always_comb begin
        case (rd_addr)
            REG_ENABLE: rd_data = enable_q;
            REG_PEND:   rd_data = pend_q;
            REG_STEER:  rd_data = steer_q;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pih_hub_chk.sv
// Module: assertion checker bound to pih_hub; observes ports and state.
// Assumes the handler's synchronous active-low reset.
module pih_hub_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] src_evt,
    input logic         ack_std,
    input logic         ack_srv,
    input logic         std_req,
    input logic         srv_req,
    input logic         vec_valid,
    input logic [N-1:0] enable_q,
    input logic [N-1:0] pend_q,
    input logic [N-1:0] steer_q
);
    // R2: every event bit is pending after its edge.
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_evt) |=> ((pend_q & $past(src_evt)) == $past(src_evt)));

    // R3: nothing enabled and pending means both lines idle.
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & enable_q) == '0) |-> (!std_req && !srv_req));

    // R4: each line requests only with a qualifying source behind it.
    p_std_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        std_req |-> (|(pend_q & enable_q & ~steer_q)));
    p_srv_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        srv_req |-> (|(pend_q & enable_q & steer_q)));

    // R6: an accepted acknowledge yields a valid vector next cycle.
    p_ack_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_std && std_req) || (ack_srv && srv_req)) |=> vec_valid);

    // R6: no accepted acknowledge, no valid vector.
    p_idle_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ack_std && std_req) && !(ack_srv && srv_req)) |=> !vec_valid);
endmodule

bind pih_hub pih_hub_chk #(.N(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_evt   (src_evt),
    .ack_std   (ack_std),
    .ack_srv   (ack_srv),
    .std_req   (std_req),
    .srv_req   (srv_req),
    .vec_valid (vec_valid),
    .enable_q  (enable_q),
    .pend_q    (pend_q),
    .steer_q   (steer_q)
);

// File: tb/pih_hub_bench.sv
`timescale 1ns/100ps
module pih_hub_bench;
    localparam int          N    = 16;
    localparam logic [15:0] BASE = 16'h2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] src_evt = '0;
    logic        ack_std = 1'b0, ack_srv = 1'b0;
    logic        std_req, srv_req, vec_valid;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_en = '0, m_pend = '0, m_st = '0;

    always #2.5 clk = ~clk;

    pih_hub #(.NUM_SRC(N), .VEC_W(16), .VEC_BASE(BASE)) u_pih_hub (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_evt(src_evt), .ack_std(ack_std), .ack_srv(ack_srv),
        .std_req(std_req), .srv_req(srv_req), .vec_valid(vec_valid),
        .vec_addr(vec_addr)
    );

    function automatic int lowest(input logic [15:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [15:0] vec_of(input int i);
        return BASE + 16'(2 * i);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare all readable registers against the model while inputs are idle.
    task automatic check_regs(input string tag);
        logic [15:0] exp;
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #0.4;
            exp = (a == 0) ? m_en : (a == 1) ? m_pend : (a == 2) ? m_st : 16'h0;
            chk($sformatf("%s R9 reg%0d", tag, a), 32'(rd_data), 32'(exp));
        end
    endtask

    // Apply one cycle of stimulus, update the model and check outputs.
    task automatic do_cyc(input logic [15:0] evt, input logic as, input logic av,
                          input logic we, input logic [1:0] wa, input logic [15:0] wd,
                          input string tag);
        int ws, wv;
        logic [15:0] np;
        logic ev_v;
        logic [15:0] ev_a;
        src_evt = evt; ack_std = as; ack_srv = av;
        wr_en = we; wr_addr = wa; wr_data = wd;
        ws = lowest(m_pend & m_en & ~m_st);
        wv = lowest(m_pend & m_en & m_st);
        np = m_pend;
        if (we && wa == 2'd1) np = np & wd;
        if (as && ws >= 0) np[ws] = 1'b0;
        if (av && wv >= 0) np[wv] = 1'b0;
        np = np | evt;
        ev_v = (as && ws >= 0) || (av && wv >= 0);
        ev_a = (av && wv >= 0) ? vec_of(wv) : (ws >= 0 ? vec_of(ws) : 16'h0);
        @(posedge clk);
        #1;
        m_pend = np;
        if (we && wa == 2'd0) m_en = wd;
        if (we && wa == 2'd2) m_st = wd;
        src_evt = '0; ack_std = 1'b0; ack_srv = 1'b0; wr_en = 1'b0;
        chk({tag, " R4 std_req"}, 32'(std_req), 32'(|(m_pend & m_en & ~m_st)));
        chk({tag, " R4 srv_req"}, 32'(srv_req), 32'(|(m_pend & m_en & m_st)));
        chk({tag, " R6 vec_valid"}, 32'(vec_valid), 32'(ev_v));
        if (ev_v) chk({tag, " R5 vec_addr"}, 32'(vec_addr), 32'(ev_a));
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state.
        chk("R1 std_req", 32'(std_req), 0);
        chk("R1 srv_req", 32'(srv_req), 0);
        chk("R1 vec_valid", 32'(vec_valid), 0);
        chk("R1 vec_addr", 32'(vec_addr), 0);
        check_regs("R1");

        // R2/R3: event on a disabled source is latched but requests nothing.
        do_cyc(16'h0020, 0, 0, 0, 0, 0, "R2");
        chk("R3 pend held while disabled", 32'(m_pend[5]), 1);
        chk("R3 no std_req", 32'(std_req), 0);
        check_regs("R3");

        // R5/R6: enable all; two standard sources, lowest wins.
        do_cyc(16'h0200, 0, 0, 1, 2'd0, 16'hFFFF, "R5 setup");
        do_cyc(0, 1, 0, 0, 0, 0, "R6 ack std");
        chk("R5 vec of 5", 32'(vec_addr), 32'(vec_of(5)));
        do_cyc(0, 1, 0, 0, 0, 0, "R6 ack std 2");
        chk("R5 vec of 9", 32'(vec_addr), 32'(vec_of(9)));
        do_cyc(0, 1, 0, 0, 0, 0, "R6 ack idle");
        chk("R6 idle ack no vector", 32'(vec_valid), 0);

        // R7: one source on each line, both acknowledged together.
        do_cyc(16'h0000, 0, 0, 1, 2'd2, 16'h0008, "R7 steer");
        do_cyc(16'h0208, 0, 0, 0, 0, 0, "R7 events");
        chk("R4 both lines", 32'({std_req, srv_req}), 32'(2'b11));
        do_cyc(0, 1, 1, 0, 0, 0, "R7 dual ack");
        chk("R7 server vector", 32'(vec_addr), 32'(vec_of(3)));
        chk("R7 both cleared", 32'(m_pend), 0);
        check_regs("R7");

        // R8: event collides with acknowledge clear, then with software clear.
        do_cyc(16'h0080, 0, 0, 0, 0, 0, "R8 arm");
        do_cyc(16'h0080, 1, 0, 0, 0, 0, "R8 ack race");
        chk("R8 pend survives ack", 32'(m_pend[7]), 1);
        do_cyc(16'h0080, 0, 0, 1, 2'd1, 16'h0000, "R8 sw race");
        check_regs("R8");

        // R9: writing ones to pending cannot set bits; software clear works.
        do_cyc(0, 0, 0, 1, 2'd1, 16'hFFFF, "R9 ones");
        do_cyc(0, 0, 0, 1, 2'd1, 16'h0000, "R9 clear");
        chk("R9 cleared", 32'(std_req), 0);
        check_regs("R9");

        // Random mix with a fixed seed.
        void'($urandom(32'h5EED1));
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] e;
            logic we;
            logic [1:0] wa;
            e  = ($urandom % 4 == 0) ? 16'(1 << ($urandom % N)) : 16'h0;
            we = ($urandom % 10 == 0);
            wa = 2'($urandom % 4);
            do_cyc(e, 1'($urandom % 3 == 0), 1'($urandom % 3 == 0),
                   we, wa, 16'($urandom), "rand");
            if (n % 100 == 0) check_regs("rand");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule